// File: doc/BRIEF.md
# Watch-Point Trigger Unit

This block watches signals of a user design while it runs at speed and raises an interrupt when a programmed condition is met. It is built from a number of comparison slots. Each slot has three inputs: a monitored bus, a watch value, and a 4-bit condition code. The condition is either a relational test against the watch value or an edge test on the monitored signal. Every clock cycle, each slot gives one match bit.

The match bits of the enabled slots are merged by AND or by OR into one hit. A qualification counter can then require the hit to be seen several times before anything fires. The count runs in one of two modes: consecutive cycles, or cumulative cycles with gaps allowed. When the qualified trigger fires, it sets a sticky interrupt flag. A host clears the flag with an acknowledge input. Halting the clock, loading the watch values and reading back design state are handled outside this block.

Top module: `wp_trigger_unit`

## Requirements
- R1: Condition codes compare the slot's monitored bus with its watch value as unsigned numbers: 0 matches when monitored > watch, 1 when >=, 2 when <, 3 when <=, 4 when not equal, 5 when equal.
- R2: Codes 6, 7 and 8 look at bit 0 of the monitored bus. Each slot keeps a registered copy of that bit from the previous clock, and this copy is 0 after reset. Code 6 matches when the bit goes from 0 to 1, code 7 when it goes from 1 to 0, and code 8 on either change. The watch value is not used by these codes.
- R3: Codes 9 to 15 never match.
- R4: A slot whose enable bit is 0 is ignored. In OR mode (`comb_or_i`=1) the hit is true when any enabled slot matches. In AND mode it is true when every enabled slot matches. With no slot enabled, there is never a hit.
- R5: With a count target of 0 or 1, the first hit cycle fires the trigger, and `irq_o` is high after the clock edge that ends that cycle.
- R6: In consecutive mode (`cum_mode_i`=0), the trigger fires on the cycle that completes a run of target hit cycles in a row. Any cycle without a hit sets the count back to zero.
- R7: In cumulative mode (`cum_mode_i`=1), the trigger fires on the target-th hit cycle, and the hit cycles need not be adjacent. Cycles without a hit leave the count unchanged.
- R8: `irq_o` stays high until `ack_i` is sampled high, and it is then low after that edge. An acknowledge sets the count to zero in both modes, and so does each firing.
- R9: If the trigger fires in the same cycle as an acknowledge, `irq_o` is high after that edge.
- R10: After reset, `irq_o` is low, the count is zero and the stored previous samples are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_i | input | NUM_SLOTS*DATA_W | Monitored buses, slot k at bits [k*DATA_W +: DATA_W] |
| watch_i | input | NUM_SLOTS*DATA_W | Watch values, one per slot |
| cond_i | input | NUM_SLOTS*4 | Condition code per slot |
| slot_en_i | input | NUM_SLOTS | Slot enables |
| comb_or_i | input | 1 | 1 = OR the slot matches, 0 = AND them |
| cum_mode_i | input | 1 | 1 = cumulative count, 0 = consecutive count |
| target_i | input | CNT_W | Number of hit cycles required |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Sticky interrupt |

## Verification
An acknowledge and a new firing can fall in the same cycle, and the block must then keep the interrupt set and restart the count. The bench provokes this in two ways. In one, it holds the acknowledge high during whole sweeps, so that every firing coincides with it. In the other, it runs a long pattern where hits and acknowledges are placed on independent periods and overlap in many cycles. A cycle-level model built from the requirements predicts the interrupt after every edge, and each prediction is compared with `irq_o`.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int COND_W = 4;

   typedef enum logic [COND_W-1:0] {
      WC_GT    = 4'd0,
      WC_GE    = 4'd1,
      WC_LT    = 4'd2,
      WC_LE    = 4'd3,
      WC_NE    = 4'd4,
      WC_EQ    = 4'd5,
      WC_RISE  = 4'd6,
      WC_FALL  = 4'd7,
      WC_TOGL  = 4'd8
   } wp_cond_e;
endpackage

// File: rtl/wp_slot_cmp.sv
module wp_slot_cmp
   import wp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] mon_i,
   input  logic [DATA_W-1:0] watch_i,
   input  logic [COND_W-1:0] cond_i,
   output logic              match_o
);
   logic prev_q;
   logic cur_b;

   assign cur_b = mon_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur_b;
   end

   always_comb begin
      case (cond_i)
         WC_GT:   match_o = (mon_i >  watch_i);
         WC_GE:   match_o = (mon_i >= watch_i);
         WC_LT:   match_o = (mon_i <  watch_i);
         WC_LE:   match_o = (mon_i <= watch_i);
         WC_NE:   match_o = (mon_i != watch_i);
         WC_EQ:   match_o = (mon_i == watch_i);
         WC_RISE: match_o = cur_b & ~prev_q;
         WC_FALL: match_o = ~cur_b & prev_q;
         WC_TOGL: match_o = cur_b ^ prev_q;
         default: match_o = 1'b0;
      endcase
   end

   AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i > 4'd8) |-> !match_o); // R3
   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cond_i == 4'd8) && match_o) |=> (prev_q != $past(prev_q))); // R2
endmodule

// File: rtl/wp_combine.sv
module wp_combine #(
   parameter int NUM_SLOTS = 2
) (
   input  logic [NUM_SLOTS-1:0] match_i,
   input  logic [NUM_SLOTS-1:0] en_i,
   input  logic                 or_mode_i,
   output logic                 hit_o
);
   logic any_v;
   logic all_v;

   assign any_v = |(match_i & en_i);
   assign all_v = &(match_i | ~en_i);
   assign hit_o = (|en_i) & (or_mode_i ? any_v : all_v);

   always_comb begin
      if (en_i == '0) AST_NONE_ENABLED: assert (!hit_o); // R4
   end
endmodule

// File: rtl/wp_qualify.sv
module wp_qualify #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_i,
   input  logic             cum_mode_i,
   input  logic [CNT_W-1:0] target_i,
   input  logic             ack_i,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W-1:0] tgt_eff;
   logic             fire;

   assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign tgt_eff = (target_i <= CNT_ONE) ? CNT_ONE : target_i;
   assign fire    = hit_i && (cnt_inc >= {1'b0, tgt_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= fire | (irq_q & ~ack_i);
         if (ack_i || fire)   cnt_q <= '0;
         else if (hit_i)      cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_inc[CNT_W-1:0];
         else if (!cum_mode_i) cnt_q <= '0;
      end
   end

   assign irq_o = irq_q;

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack_i) |=> irq_q); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !fire) |=> !irq_q); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && fire) |=> irq_q); // R9
   AST_FIRST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && (target_i <= CNT_ONE)) |=> irq_q); // R5
   AST_CONSEC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cum_mode_i && !hit_i) |=> (cnt_q == '0)); // R6
   AST_CUM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cum_mode_i && !hit_i && !ack_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/wp_trigger_unit.sv
module wp_trigger_unit
   import wp_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SLOTS*DATA_W-1:0]   mon_i,
   input  logic [NUM_SLOTS*DATA_W-1:0]   watch_i,
   input  logic [NUM_SLOTS*COND_W-1:0]   cond_i,
   input  logic [NUM_SLOTS-1:0]          slot_en_i,
   input  logic                          comb_or_i,
   input  logic                          cum_mode_i,
   input  logic [CNT_W-1:0]              target_i,
   input  logic                          ack_i,
   output logic                          irq_o
);
   if (NUM_SLOTS < 1) begin : g_chk_slots
      $error("NUM_SLOTS must be at least 1");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("DATA_W must be at least 1");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end

   logic [NUM_SLOTS-1:0] match_v;
   logic                 hit;

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      wp_slot_cmp #(.DATA_W(DATA_W)) u_cmp (
         .clk     (clk),
         .rst_n   (rst_n),
         .mon_i   (mon_i[k*DATA_W +: DATA_W]),
         .watch_i (watch_i[k*DATA_W +: DATA_W]),
         .cond_i  (cond_i[k*COND_W +: COND_W]),
         .match_o (match_v[k])
      );
   end

   wp_combine #(.NUM_SLOTS(NUM_SLOTS)) u_comb (
      .match_i   (match_v),
      .en_i      (slot_en_i),
      .or_mode_i (comb_or_i),
      .hit_o     (hit)
   );

   wp_qualify #(.CNT_W(CNT_W)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit),
      .cum_mode_i (cum_mode_i),
      .target_i   (target_i),
      .ack_i      (ack_i),
      .irq_o      (irq_o)
   );
endmodule

// File: tb/wp_trigger_unit_tb.sv
module wp_trigger_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 2;
   localparam int DW = 4;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS*DW-1:0] mon = '0;
   logic [NS*DW-1:0] watch = '0;
   logic [NS*4-1:0]  cond = '0;
   logic [NS-1:0]    en = '0;
   logic             comb_or = 1'b1;
   logic             cum = 1'b0;
   logic [CW-1:0]    target = 4'd1;
   logic             ack = 1'b1;
   logic             irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_trigger_unit #(.NUM_SLOTS(NS), .DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mon_i(mon), .watch_i(watch), .cond_i(cond),
      .slot_en_i(en), .comb_or_i(comb_or), .cum_mode_i(cum), .target_i(target),
      .ack_i(ack), .irq_o(irq)
   );

   task automatic chk(input logic exp, input string req);
      n_chk++;
      if (irq !== exp) begin
         n_bad++;
         $display("FAIL %s: irq=%b expected %b at %0t", req, irq, exp, $time);
      end
   endtask

   // inputs are set right after a falling edge; one rising edge later irq is checked
   task automatic cyc(input logic exp, input string req);
      @(negedge clk);
      chk(exp, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic prev;
      repeat (3) @(negedge clk);
      chk(1'b0, "R10 irq low in reset");
      rst_n = 1'b1;
      // R10/R2: stored previous sample is 0, so a 1 on the first cycle is a rising edge
      en = 2'b01; cond[3:0] = 4'd6; mon[0] = 1'b1;
      cyc(1'b1, "R10 prev sample zero");

      // R1: exhaustive relational sweep on slot 0, ack held high
      for (int c = 0; c <= 5; c++) begin
         for (int m = 0; m < 16; m++) begin
            for (int w = 0; w < 16; w++) begin
               logic e;
               cond[3:0] = 4'(c); mon[3:0] = 4'(m); watch[3:0] = 4'(w);
               case (c)
                  0: e = m > w;  1: e = m >= w;  2: e = m < w;
                  3: e = m <= w; 4: e = m != w;  default: e = m == w;
               endcase
               cyc(e, "R1 relational");
            end
         end
      end

      // R3: unused codes never match
      for (int c = 9; c < 16; c++) begin
         for (int m = 0; m < 16; m++) begin
            cond[3:0] = 4'(c); mon[3:0] = 4'(m); watch[3:0] = 4'(m);
            cyc(1'b0, "R3 unused code");
         end
      end

      // R2: edge codes on bit 0, watch value irrelevant
      for (int c = 6; c <= 8; c++) begin
         cond[3:0] = 4'd5; mon[3:0] = 4'd0; watch[3:0] = 4'd9;
         cyc(1'b0, "R2 edge setup");
         prev = 1'b0;
         cond[3:0] = 4'(c);
         for (int i = 0; i < 32; i++) begin
            logic b, e;
            b = 1'(((i * 5) + (i / 3)) % 2);
            mon[3:0] = {3'(i), b};
            watch[3:0] = 4'(i);
            e = (c == 6) ? (b & ~prev) : (c == 7) ? (~b & prev) : (b ^ prev);
            cyc(e, "R2 edge");
            prev = b;
         end
      end

      // R4: combine sweep with equality slots
      cond = {4'd5, 4'd5}; watch = {4'd7, 4'd3};
      for (int v = 0; v < 16; v++) begin
         logic m0, m1, e, en0, en1;
         en0 = v[0]; en1 = v[1]; m0 = v[2]; m1 = v[3];
         for (int o = 0; o < 2; o++) begin
            en = {en1, en0}; comb_or = o[0];
            mon = {(m1 ? 4'd7 : 4'd6), (m0 ? 4'd3 : 4'd2)};
            if (o == 1) e = (en0 & m0) | (en1 & m1);
            else        e = (en0 | en1) & (~en0 | m0) & (~en1 | m1);
            cyc(e, "R4 combine");
         end
      end

      // R5..R9: qualification model against a long hit/ack pattern
      en = 2'b01; comb_or = 1'b1; cond[3:0] = 4'd5; watch[3:0] = 4'd3;
      for (int md = 0; md < 2; md++) begin
         for (int t = 0; t <= 4; t++) begin
            int cnt, tg;
            logic irq_m;
            ack = 1'b1; mon[3:0] = 4'd4; cum = md[0]; target = 4'(t);
            cyc(1'b0, "R8 clear before run");
            cnt = 0; irq_m = 1'b0; tg = (t <= 1) ? 1 : t;
            for (int i = 0; i < 60; i++) begin
               logic h, a, f;
               h = ((i % 5) != 2) && ((i % 11) != 7);
               a = ((i % 9) == 8);
               f = h && (cnt + 1 >= tg);
               irq_m = f | (irq_m & ~a);
               if (a || f)      cnt = 0;
               else if (h)      cnt = cnt + 1;
               else if (md == 0) cnt = 0;
               mon[3:0] = h ? 4'd3 : 4'd4; ack = a;
               if (a && f)       cyc(irq_m, "R9 fire with ack");
               else if (t <= 1)  cyc(irq_m, "R5 first hit");
               else if (md == 0) cyc(irq_m, "R6 consecutive");
               else              cyc(irq_m, "R7 cumulative");
            end
         end
      end

      // R8: sticky until acknowledged
      ack = 1'b0; cum = 1'b0; target = 4'd1; mon[3:0] = 4'd3;
      cyc(1'b1, "R8 set");
      mon[3:0] = 4'd4;
      cyc(1'b1, "R8 held");
      cyc(1'b1, "R8 held");
      ack = 1'b1;
      cyc(1'b0, "R8 ack clears");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule